// File: doc/BRIEF.md
# L1 Data Memory Configuration Router

This block holds the 32-bit control word for the level-one data memory and uses it to route each data access. Two address generators present requests, each with an address, a valid bit and a cacheable flag. For each request the block decides, in the same cycle, whether the access is served by cache or by SRAM, which of the two data banks a cached access uses, and which of the two ports an uncached fetch takes.

The control word is written and read through a plain register port. A two-bit mode field sets how much of each bank acts as cache. A bank-select bit picks the address bit that chooses the cache bank. Each generator has its own port-preference bit. When a write turns all cache off, the block raises a one-clock pulse that invalidates every cache line. The cache arrays, tags, protection lookaside buffer contents and bus fabric sit outside this block.

Top module: `l1d_route_ctrl`

## Requirements
- R1: After reset `rd_data` reads 0x0000_1001 and `prot_chk_en` is 1.
- R2: A write stores only bits 0, 2, 3, 4, 12 and 13 of `wr_data`. All other bits read as zero, and a read returns the stored value in the cycle after the write.
- R3: A write whose mode field (bits 3:2) is 01 is ignored in full: `rd_data` stays unchanged and no invalidate pulse is raised.
- R4: In mode 00, no request is routed to cache (`rt_cache` is 0 even for valid cacheable requests).
- R5: In mode 10, every valid cacheable request routes to cache in bank A (`rt_bank_b` = 0), whatever bit 4 and the address hold.
- R6: In mode 11 with bit 4 = 0, a valid cacheable request uses address bit 14 to pick the bank: 1 selects bank A (`rt_bank_b` = 0) and 0 selects bank B (`rt_bank_b` = 1).
- R7: In mode 11 with bit 4 = 1, address bit 23 picks the bank, with the same polarity as in R6.
- R8: A valid uncached request from generator 0 drives `rt_port_b` from bit 12, and one from generator 1 from bit 13 (1 = port B). Invalid requests and cached requests drive `rt_port_b` = 0. A request that is not cached drives `rt_bank_b` = 0.
- R9: A write of mode 00 while the stored mode is 10 or 11 raises `inv_all` for exactly the one cycle after the write. Any other write leaves `inv_all` low.
- R10: `prot_chk_en` follows bit 0 of the stored word. When it is 1, the lookaside buffer check is enabled. When it is 0, only minimal address checking is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Stored control word |
| prot_chk_en | output | 1 | Lookaside buffer check enable |
| req_valid | input | 2 | Request valid, one bit per generator |
| req_cacheable | input | 2 | Request cacheable flag, per generator |
| req_addr | input | 64 | Request addresses, generator g in bits [32g+31:32g] |
| rt_cache | output | 2 | 1 = routed to cache, per generator |
| rt_bank_b | output | 2 | 1 = bank B, 0 = bank A, per generator |
| rt_port_b | output | 2 | 1 = port B, 0 = port A, per generator |
| inv_all | output | 1 | One-clock invalidate-all-lines pulse |

## Verification
The stored word drives every routing output through logic with no registers in the path. A corrupted mode, bank-select or preference bit therefore shows on `rt_cache`, `rt_bank_b` or `rt_port_b` in the same cycle as the next request that depends on it, and on `rd_data` at once. A wrong record of the previous mode shows only on `inv_all`, one cycle after the write that leaves cache. For that reason the bench runs both kinds of mode transition and checks both cycles after each one.

// File: rtl/l1d_route_pkg.sv
package l1d_route_pkg;
    localparam int REG_W     = 32;
    localparam int CHK_BIT   = 0;
    localparam int MODE_LSB  = 2;
    localparam int BSEL_BIT  = 4;
    localparam int PREF_LSB  = 12;
    localparam logic [REG_W-1:0] RESET_VAL = 32'h0000_1001;
    localparam logic [REG_W-1:0] WR_MASK   = 32'h0000_301D;

    typedef enum logic [1:0] {
        MODE_ALL_SRAM = 2'b00,
        MODE_RSVD     = 2'b01,
        MODE_A_CACHE  = 2'b10,
        MODE_AB_CACHE = 2'b11
    } dmode_e;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic             inv;
    } cfg_state_t;
endpackage

// File: rtl/l1d_cfg_reg.sv
module l1d_cfg_reg
    import l1d_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q,
    output logic             inv_q
);
    cfg_state_t st_d, st_q;
    dmode_e     new_mode, cur_mode;

    always_comb begin
        new_mode = dmode_e'(wr_data[MODE_LSB +: 2]);
        cur_mode = dmode_e'(st_q.cfg[MODE_LSB +: 2]);
        st_d     = st_q;
        st_d.inv = 1'b0;
        if (wr_en && new_mode != MODE_RSVD) begin
            st_d.cfg = wr_data & WR_MASK;
            if (new_mode == MODE_ALL_SRAM &&
                (cur_mode == MODE_A_CACHE || cur_mode == MODE_AB_CACHE))
                st_d.inv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= RESET_VAL;
            st_q.inv <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;
    assign inv_q = st_q.inv;
endmodule

// File: rtl/l1d_req_route.sv
module l1d_req_route
    import l1d_route_pkg::*;
(
    input  logic   valid,
    input  logic   cacheable,
    input  logic   sel_lo_bit,
    input  logic   sel_hi_bit,
    input  dmode_e mode,
    input  logic   bank_sel,
    input  logic   pref_b,
    output logic   to_cache,
    output logic   bank_b,
    output logic   port_b
);
    logic bank_bit;

    always_comb begin
        bank_bit = bank_sel ? sel_hi_bit : sel_lo_bit;
        to_cache = 1'b0;
        bank_b   = 1'b0;
        port_b   = 1'b0;
        if (valid) begin
            unique case (mode)
                MODE_A_CACHE: begin
                    to_cache = cacheable;
                end
                MODE_AB_CACHE: begin
                    to_cache = cacheable;
                    bank_b   = cacheable & ~bank_bit;
                end
                default: begin
                    to_cache = 1'b0;
                end
            endcase
            port_b = ~to_cache & pref_b;
        end
    end
endmodule

// File: rtl/l1d_route_ctrl.sv
module l1d_route_ctrl
    import l1d_route_pkg::*;
#(
    parameter int NUM_GEN = 2,
    parameter int ADDR_W  = 32,
    parameter int LO_SEL  = 14,
    parameter int HI_SEL  = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [31:0]               wr_data,
    output logic [31:0]               rd_data,
    output logic                      prot_chk_en,
    input  logic [NUM_GEN-1:0]        req_valid,
    input  logic [NUM_GEN-1:0]        req_cacheable,
    input  logic [NUM_GEN*ADDR_W-1:0] req_addr,
    output logic [NUM_GEN-1:0]        rt_cache,
    output logic [NUM_GEN-1:0]        rt_bank_b,
    output logic [NUM_GEN-1:0]        rt_port_b,
    output logic                      inv_all
);
    logic [REG_W-1:0] cfg;
    logic             unused_addr_bits;

    l1d_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg),
        .inv_q   (inv_all)
    );

    assign rd_data          = cfg;
    assign prot_chk_en      = cfg[CHK_BIT];
    assign unused_addr_bits = ^req_addr;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        l1d_req_route u_route (
            .valid      (req_valid[g]),
            .cacheable  (req_cacheable[g]),
            .sel_lo_bit (req_addr[g*ADDR_W + LO_SEL]),
            .sel_hi_bit (req_addr[g*ADDR_W + HI_SEL]),
            .mode       (dmode_e'(cfg[MODE_LSB +: 2])),
            .bank_sel   (cfg[BSEL_BIT]),
            .pref_b     (cfg[PREF_LSB + g]),
            .to_cache   (rt_cache[g]),
            .bank_b     (rt_bank_b[g]),
            .port_b     (rt_port_b[g])
        );
    end
endmodule

// File: rtl/l1d_route_chk.sv
module l1d_route_chk #(
    parameter int NUM_GEN = 2,
    parameter int ADDR_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [31:0]               wr_data,
    input logic [31:0]               rd_data,
    input logic                      prot_chk_en,
    input logic [NUM_GEN-1:0]        req_valid,
    input logic [NUM_GEN-1:0]        req_cacheable,
    input logic [NUM_GEN*ADDR_W-1:0] req_addr,
    input logic [NUM_GEN-1:0]        rt_cache,
    input logic [NUM_GEN-1:0]        rt_bank_b,
    input logic [NUM_GEN-1:0]        rt_port_b,
    input logic                      inv_all
);
    logic unused_chk;
    assign unused_chk = ^{req_addr, prot_chk_en};

    p_unused_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~32'h0000_301D) == 32'h0);

    p_rsvd_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3:2] == 2'b01) |=> ($stable(rd_data) && !inv_all));

    p_inv_on_cache_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3:2] == 2'b00 && rd_data[3]) |=> inv_all);

    p_inv_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !inv_all);

    p_inv_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !inv_all);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        p_no_cache_in_sram_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rt_cache[g] |-> rd_data[3]);

        p_mode10_bank_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[3:2] == 2'b10 && req_valid[g] && req_cacheable[g])
            |-> (rt_cache[g] && !rt_bank_b[g]));

        p_lo_bit_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[4:2] == 3'b011 && req_valid[g] && req_cacheable[g])
            |-> (rt_bank_b[g] == !req_addr[g*ADDR_W + 14]));

        p_hi_bit_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[4:2] == 3'b111 && req_valid[g] && req_cacheable[g])
            |-> (rt_bank_b[g] == !req_addr[g*ADDR_W + 23]));

        p_uncached_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && !rt_cache[g]) |-> (rt_port_b[g] == rd_data[12 + g]));

        p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[g] |-> (!rt_cache[g] && !rt_bank_b[g] && !rt_port_b[g]));
    end
endmodule

bind l1d_route_ctrl l1d_route_chk #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/l1d_route_ctrl_test.sv
`timescale 1ns/1ps
module l1d_route_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        prot_chk_en;
    logic [1:0]  req_valid = '0;
    logic [1:0]  req_cacheable = '0;
    logic [63:0] req_addr = '0;
    logic [1:0]  rt_cache, rt_bank_b, rt_port_b;
    logic        inv_all;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    l1d_route_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .prot_chk_en(prot_chk_en),
        .req_valid(req_valid), .req_cacheable(req_cacheable), .req_addr(req_addr),
        .rt_cache(rt_cache), .rt_bank_b(rt_bank_b), .rt_port_b(rt_port_b),
        .inv_all(inv_all)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write, then sample rd_data and inv_all in the cycle after the write.
    task automatic reg_write(input logic [31:0] d, output logic [31:0] rd, output logic inv);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd = rd_data;
        inv = inv_all;
    endtask

    // Drive one request on generator g and return {cache, bank_b, port_b}.
    task automatic route(input int g, input logic v, input logic c, input logic [31:0] a,
                         output logic [2:0] res);
        @(negedge clk);
        req_valid = '0;
        req_cacheable = '0;
        req_addr = '0;
        req_valid[g] = v;
        req_cacheable[g] = c;
        req_addr[g*32 +: 32] = a;
        #1;
        res = {rt_cache[g], rt_bank_b[g], rt_port_b[g]};
    endtask

    task automatic t_reset();
        logic [2:0] r;
        check("R1 reset value", rd_data, 32'h0000_1001);
        check("R1 reset check enable", {31'b0, prot_chk_en}, 32'h1);
        check("R9 no pulse at reset", {31'b0, inv_all}, 32'h0);
        route(0, 1'b1, 1'b0, 32'h0, r);
        check("R8 gen0 uncached port B at reset", {29'b0, r}, 32'h1);
        route(1, 1'b1, 1'b0, 32'h0, r);
        check("R8 gen1 uncached port A at reset", {29'b0, r}, 32'h0);
        route(0, 1'b1, 1'b1, 32'h0080_4000, r);
        check("R4 mode 00 never caches", {29'b0, r}, 32'h1);
    endtask

    task automatic t_mask();
        logic [31:0] rd;
        logic        inv;
        logic [2:0]  r;
        reg_write(32'hFFFF_FFF3, rd, inv);
        check("R2 write mask", rd, 32'h0000_3011);
        check("R9 no pulse 00 to 00", {31'b0, inv}, 32'h0);
        route(1, 1'b1, 1'b0, 32'h0, r);
        check("R8 gen1 uses bit 13", {29'b0, r}, 32'h1);
        reg_write(32'h0000_0000, rd, inv);
        check("R2 clear", rd, 32'h0);
        check("R10 check enable off", {31'b0, prot_chk_en}, 32'h0);
        route(0, 1'b1, 1'b0, 32'h0, r);
        check("R8 gen0 port A after clear", {29'b0, r}, 32'h0);
    endtask

    task automatic t_mode10();
        logic [31:0] rd;
        logic        inv;
        logic [2:0]  r;
        reg_write(32'h0000_3009, rd, inv);
        check("R2 mode 10 stored", rd, 32'h0000_3009);
        check("R10 check enable on", {31'b0, prot_chk_en}, 32'h1);
        route(0, 1'b1, 1'b1, 32'h0000_0000, r);
        check("R5 mode 10 bank A bit14=0", {29'b0, r}, 32'h4);
        reg_write(32'h0000_3019, rd, inv);
        route(1, 1'b1, 1'b1, 32'h0000_4000, r);
        check("R5 mode 10 bank A bsel=1", {29'b0, r}, 32'h4);
        route(1, 1'b1, 1'b0, 32'h0000_0000, r);
        check("R8 mode 10 uncached gen1 port B", {29'b0, r}, 32'h1);
    endtask

    task automatic t_mode11();
        logic [31:0] rd;
        logic        inv;
        logic [2:0]  r;
        reg_write(32'h0000_000C, rd, inv);
        check("R9 no pulse 10 to 11", {31'b0, inv}, 32'h0);
        route(0, 1'b1, 1'b1, 32'h0000_4000, r);
        check("R6 bit14=1 bank A", {29'b0, r}, 32'h4);
        route(1, 1'b1, 1'b1, 32'h0080_0000, r);
        check("R6 bit14=0 bank B", {29'b0, r}, 32'h6);
        reg_write(32'h0000_001C, rd, inv);
        route(0, 1'b1, 1'b1, 32'h0080_0000, r);
        check("R7 bit23=1 bank A", {29'b0, r}, 32'h4);
        route(1, 1'b1, 1'b1, 32'h0000_4000, r);
        check("R7 bit23=0 bank B", {29'b0, r}, 32'h6);
        route(0, 1'b1, 1'b0, 32'h0000_0000, r);
        check("R8 uncached bank A port A", {29'b0, r}, 32'h0);
        route(1, 1'b0, 1'b1, 32'h0000_0000, r);
        check("R8 invalid request idle", {29'b0, r}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] rd;
        logic        inv;
        reg_write(32'h0000_3005, rd, inv);
        check("R3 reserved write ignored", rd, 32'h0000_001C);
        check("R3 no pulse on reserved", {31'b0, inv}, 32'h0);
    endtask

    task automatic t_invalidate();
        logic [31:0] rd;
        logic        inv;
        reg_write(32'h0000_0000, rd, inv);
        check("R9 pulse after 11 to 00", {31'b0, inv}, 32'h1);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {31'b0, inv_all}, 32'h0);
        reg_write(32'h0000_0008, rd, inv);
        check("R9 no pulse 00 to 10", {31'b0, inv}, 32'h0);
        reg_write(32'h0000_1000, rd, inv);
        check("R9 pulse after 10 to 00", {31'b0, inv}, 32'h1);
        check("R2 readback after leaving cache", rd, 32'h0000_1000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_mode10();
        t_mode11();
        t_reserved();
        t_invalidate();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule